// File: doc/BRIEF.md
# Burst Beat Address Sequencer

This block turns one burst command from a memory-mapped address channel into the sequence of addresses for the individual beats. A command holds a start address, a two-bit burst type, an eight-bit length field and a three-bit size field. The size field gives the bytes per beat as a power of two. Once the block accepts a command, it sends one address per beat on a valid/ready output. The address of the final beat comes with a last flag. The block takes no further command until that final beat has been handed off.

Fixed, incrementing and wrapping bursts all share one offset register. The register is added to the captured start address. A fixed burst keeps the offset at zero. An incrementing burst adds one beat size per beat. A wrapping burst also adds one beat size per beat, but folds the offset back by the wrap span, which is the beat size times the length field. Control is a two-state machine. `ST_IDLE` offers `cmd_ready`. The transition *accept* (command valid while idle) moves it to `ST_EMIT`, which drives `beat_valid`. The transition *finish* (handshake on the beat flagged last) returns it to `ST_IDLE`.

Top module: `axi_beat_addr_gen`

## Requirements
- R1: After reset `cmd_ready` is 1 and `beat_valid` is 0.
- R2: An accepted command with length field L produces exactly L+1 beat handshakes. After the last one, `beat_valid` is 0 until a new command is accepted.
- R3: Burst type 0 (fixed) presents the start address on every beat.
- R4: Burst type 1 (incrementing) presents start + i·2^size on beat i, counting from 0. The sum is taken modulo 2^ADDR_W.
- R5: Burst type 2 (wrapping) with L ≥ 1 presents start + ((i·2^size) mod (2^size·L)) on beat i.
- R6: Burst type 2 with L = 0 produces a single beat at the start address.
- R7: Burst type 3 behaves exactly as burst type 0.
- R8: `beat_last` is 1 on beat number L and 0 on every earlier beat.
- R9: While `beat_valid` is 1 and `beat_ready` is 0, `beat_addr` and `beat_last` hold their values. The sequence advances only on a handshake.
- R10: `cmd_ready` goes to 0 in the cycle after a command is accepted. It stays 0 until the last beat's handshake, and is 1 in the cycle after that handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block idle and able to take a command |
| cmd_addr | input | ADDR_W | Start address |
| cmd_burst | input | 2 | Burst type: 0 fixed, 1 incrementing, 2 wrapping, 3 treated as fixed |
| cmd_len | input | LEN_W | Length field (beats minus one) |
| cmd_size | input | SIZE_W | Log2 of bytes per beat |
| beat_valid | output | 1 | Beat address valid |
| beat_ready | input | 1 | Consumer takes the beat address |
| beat_addr | output | ADDR_W | Address of the current beat |
| beat_last | output | 1 | Current beat is the final one of the burst |

## Verification
The hardest case to reach is the fold-back of a wrapping burst whose span is not a power of two. The fold must also land while the consumer is stalling. The offset then has to cross the span on exactly one handshake and stay frozen across the stall. To reach it, the stimulus issues wrapping bursts with lengths 3 and 5 and holds `beat_ready` low on alternate beats. Each address is compared against a modulo computed in the bench, both while stalled and at the handshake.

// File: rtl/abg_pkg.sv
package abg_pkg;

    typedef enum logic [1:0] {
        BT_FIXED = 2'd0,
        BT_INCR  = 2'd1,
        BT_WRAP  = 2'd2,
        BT_RSVD  = 2'd3
    } burst_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_EMIT = 1'b1
    } state_e;

    typedef enum logic [1:0] {
        MODE_HOLD   = 2'd0,
        MODE_LINEAR = 2'd1,
        MODE_WRAP   = 2'd2
    } step_mode_e;

    // Maps a burst type to the way the offset moves; a wrapping burst of one
    // beat never moves, so the zero span is never used.
    function automatic step_mode_e decode_mode(input logic [1:0] bt, input logic len_zero);
        step_mode_e m;
        unique case (burst_e'(bt))
            BT_INCR:  m = MODE_LINEAR;
            BT_WRAP:  m = len_zero ? MODE_HOLD : MODE_WRAP;
            BT_FIXED: m = MODE_HOLD;
            BT_RSVD:  m = MODE_HOLD;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/abg_ctrl_fsm.sv
module abg_ctrl_fsm
    import abg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_valid,
    input  logic beat_ready,
    input  logic at_last,
    output logic cmd_ready,
    output logic beat_valid,
    output logic load,
    output logic advance
);

    state_e state_q;
    state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (cmd_valid)              state_d = ST_EMIT;  // accept
            ST_EMIT: if (beat_ready && at_last)  state_d = ST_IDLE;  // finish
        endcase
    end

    always_comb begin
        cmd_ready  = 1'b0;
        beat_valid = 1'b0;
        unique case (state_q)
            ST_IDLE: cmd_ready  = 1'b1;
            ST_EMIT: beat_valid = 1'b1;
        endcase
        load    = cmd_ready && cmd_valid;
        advance = beat_valid && beat_ready;
    end

    // R10: command and beat sides never offered together
    a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_ready && beat_valid));

    // R2: an accepted command always opens a burst
    a_r2_accept_opens: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> beat_valid);

endmodule

// File: rtl/abg_beat_count.sv
module abg_beat_count #(
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             advance,
    input  logic [LEN_W-1:0] len_in,
    output logic             at_last
);

    logic [LEN_W-1:0] cnt_q;
    logic [LEN_W-1:0] len_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            len_q <= '0;
        end else if (load) begin
            cnt_q <= '0;
            len_q <= len_in;
        end else if (advance && !at_last) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign at_last = (cnt_q == len_q);

    // R2: the beat index never runs past the length field
    a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= len_q);

endmodule

// File: rtl/abg_offset_gen.sv
module abg_offset_gen
    import abg_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 8,
    parameter int SIZE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              advance,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [1:0]        cmd_burst,
    input  logic [LEN_W-1:0]  cmd_len,
    input  logic [SIZE_W-1:0] cmd_size,
    output logic [ADDR_W-1:0] beat_addr
);

    localparam int PAD_W = ADDR_W - LEN_W;

    logic [ADDR_W-1:0] start_q;
    logic [ADDR_W-1:0] step_q;
    logic [ADDR_W-1:0] span_q;
    logic [ADDR_W-1:0] off_q;
    step_mode_e        mode_q;

    logic [ADDR_W-1:0] step_in;
    logic [ADDR_W-1:0] span_in;
    logic [ADDR_W-1:0] sum;
    logic [ADDR_W-1:0] off_d;

    assign step_in = {{(ADDR_W-1){1'b0}}, 1'b1} << cmd_size;
    assign span_in = step_in * {{PAD_W{1'b0}}, cmd_len};
    assign sum     = off_q + step_q;

    always_comb begin
        off_d = off_q;
        unique case (mode_q)
            MODE_HOLD:   off_d = '0;
            MODE_LINEAR: off_d = sum;
            MODE_WRAP:   off_d = (sum >= span_q) ? (sum - span_q) : sum;
            default:     off_d = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            start_q <= '0;
            step_q  <= '0;
            span_q  <= '0;
            off_q   <= '0;
            mode_q  <= MODE_HOLD;
        end else if (load) begin
            start_q <= cmd_addr;
            step_q  <= step_in;
            span_q  <= span_in;
            off_q   <= '0;
            mode_q  <= decode_mode(cmd_burst, cmd_len == '0);
        end else if (advance) begin
            off_q   <= off_d;
        end
    end

    assign beat_addr = start_q + off_q;

    // R3 / R7: non-moving bursts keep a zero offset
    a_r3_hold_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_HOLD) |-> (off_q == '0));

    // R5: a wrapping offset always stays inside its span
    a_r5_wrap_inside: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_WRAP) |-> (off_q < span_q));

endmodule

// File: rtl/axi_beat_addr_gen.sv
module axi_beat_addr_gen #(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 8,
    parameter int SIZE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [1:0]        cmd_burst,
    input  logic [LEN_W-1:0]  cmd_len,
    input  logic [SIZE_W-1:0] cmd_size,
    output logic              beat_valid,
    input  logic              beat_ready,
    output logic [ADDR_W-1:0] beat_addr,
    output logic              beat_last
);

    logic load;
    logic advance;
    logic at_last;

    abg_ctrl_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_valid  (cmd_valid),
        .beat_ready (beat_ready),
        .at_last    (at_last),
        .cmd_ready  (cmd_ready),
        .beat_valid (beat_valid),
        .load       (load),
        .advance    (advance)
    );

    abg_beat_count #(.LEN_W(LEN_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .advance (advance),
        .len_in  (cmd_len),
        .at_last (at_last)
    );

    abg_offset_gen #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .SIZE_W(SIZE_W)) u_off (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .advance   (advance),
        .cmd_addr  (cmd_addr),
        .cmd_burst (cmd_burst),
        .cmd_len   (cmd_len),
        .cmd_size  (cmd_size),
        .beat_addr (beat_addr)
    );

    assign beat_last = beat_valid && at_last;

    // R9: a stalled beat keeps its address and flag
    a_r9_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid && !beat_ready) |=>
            (beat_valid && $stable(beat_addr) && $stable(beat_last)));

    // R2 / R10: handing off the last beat closes the burst
    a_r10_finish_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid && beat_ready && beat_last) |=> (cmd_ready && !beat_valid));

    // R10: a handoff that is not the last keeps the command side closed
    a_r10_mid_closed: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid && beat_ready && !beat_last) |=> (!cmd_ready && beat_valid));

endmodule

// File: tb/tb_axi_beat_addr_gen.sv
module tb_axi_beat_addr_gen;

    localparam int ADDR_W = 32;
    localparam int LEN_W  = 8;
    localparam int SIZE_W = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cmd_valid = 1'b0;
    logic              cmd_ready;
    logic [ADDR_W-1:0] cmd_addr = '0;
    logic [1:0]        cmd_burst = '0;
    logic [LEN_W-1:0]  cmd_len = '0;
    logic [SIZE_W-1:0] cmd_size = '0;
    logic              beat_valid;
    logic              beat_ready = 1'b0;
    logic [ADDR_W-1:0] beat_addr;
    logic              beat_last;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    axi_beat_addr_gen #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .SIZE_W(SIZE_W)) dut (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_addr(cmd_addr), .cmd_burst(cmd_burst),
        .cmd_len(cmd_len), .cmd_size(cmd_size),
        .beat_valid(beat_valid), .beat_ready(beat_ready),
        .beat_addr(beat_addr), .beat_last(beat_last)
    );

    task automatic chk(input string tag, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    function automatic logic [ADDR_W-1:0] exp_addr(input logic [ADDR_W-1:0] a,
            input int bt, input int len, input int size, input int i);
        longint step = longint'(1) << size;
        logic [ADDR_W-1:0] r;
        if (bt == 1)                 r = a + ADDR_W'(i * step);
        else if (bt == 2 && len > 0) r = a + ADDR_W'((i * step) % (step * len));
        else                         r = a;
        return r;
    endfunction

    // Issues one command and walks the whole burst; stall_odd holds ready low
    // for one cycle before each odd beat.
    task automatic run_burst(input string tag, input logic [ADDR_W-1:0] a,
            input int bt, input int len, input int size, input bit stall_odd);
        int beats = 0;
        @(negedge clk);
        chk({tag, " R10 idle ready"}, cmd_ready, 1);
        cmd_valid = 1'b1; cmd_addr = a; cmd_burst = 2'(bt);
        cmd_len = LEN_W'(len); cmd_size = SIZE_W'(size);
        @(negedge clk);
        cmd_valid = 1'b0;
        for (int i = 0; i <= len; i++) begin
            logic [ADDR_W-1:0] e = exp_addr(a, bt, len, size, i);
            if (stall_odd && (i % 2 == 1)) begin
                beat_ready = 1'b0;
                chk({tag, " R9 stalled addr"}, beat_addr, e);
                @(negedge clk);
                chk({tag, " R9 held addr"}, beat_addr, e);
                chk({tag, " R9 held last"}, beat_last, (i == len));
            end
            chk({tag, " R10 busy"}, cmd_ready, 0);
            chk({tag, " R2 valid"}, beat_valid, 1);
            chk({tag, " R3 R4 R5 R7 addr"}, beat_addr, e);
            chk({tag, " R8 last"}, beat_last, (i == len));
            beat_ready = 1'b1;
            if (beat_valid) beats++;
            @(negedge clk);
            beat_ready = 1'b0;
        end
        chk({tag, " R2 beat count"}, beats, len + 1);
        chk({tag, " R2 valid drops"}, beat_valid, 0);
        chk({tag, " R10 ready back"}, cmd_ready, 1);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1 cmd_ready", cmd_ready, 1);
        chk("R1 beat_valid", beat_valid, 0);
    endtask

    task automatic t_fixed();    run_burst("fixed",   32'h0000_1230, 0, 4, 2, 1'b0); endtask
    task automatic t_incr();     run_burst("incr",    32'h0000_4000, 1, 7, 2, 1'b0); endtask
    task automatic t_incr_top(); run_burst("incrtop", 32'hFFFF_FFF8, 1, 3, 2, 1'b0); endtask
    task automatic t_wrap3();    run_burst("wrap3",   32'h0000_0100, 2, 3, 2, 1'b1); endtask
    task automatic t_wrap5();    run_burst("wrap5",   32'h0000_0200, 2, 5, 3, 1'b1); endtask
    task automatic t_wrap0();    run_burst("R6 wrap0", 32'h0000_0ABC, 2, 0, 2, 1'b0); endtask
    task automatic t_rsvd();     run_burst("R7 rsvd", 32'h0000_0040, 3, 3, 1, 1'b1); endtask
    task automatic t_incr_stall(); run_burst("incrstall", 32'h0000_8000, 1, 6, 0, 1'b1); endtask

    // R10: a command offered mid-burst is not taken
    task automatic t_cmd_ignored();
        @(negedge clk);
        cmd_valid = 1'b1; cmd_addr = 32'h500; cmd_burst = 2'd1;
        cmd_len = 8'd2; cmd_size = 3'd2;
        @(negedge clk);
        cmd_addr = 32'h9000; cmd_len = 8'd0;
        for (int i = 0; i <= 2; i++) begin
            chk("R10 ignored cmd_ready", cmd_ready, 0);
            chk("R10 ignored addr", beat_addr, 32'h500 + 4 * i);
            chk("R10 ignored last", beat_last, (i == 2));
            beat_ready = 1'b1;
            @(negedge clk);
        end
        cmd_valid = 1'b0; beat_ready = 1'b0;
        chk("R10 ignored ready back", cmd_ready, 1);
        chk("R2 ignored valid", beat_valid, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_fixed();
        t_incr();
        t_incr_top();
        t_wrap3();
        t_wrap5();
        t_wrap0();
        t_rsvd();
        t_incr_stall();
        t_cmd_ignored();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule